// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block keeps the sign state of the most recent register result in a 16-bit load/store processor and uses it to decide conditional branches. Each time the datapath writes a general-purpose register, the written value is classified as negative, zero or positive. That classification is held in a three-bit flag register with exactly one bit set.

The currently fetched instruction word is decoded in parallel. When its top four bits carry the conditional-branch opcode, its three-bit condition field is compared against the stored flags. The branch is taken when any selected condition is currently true. The decision is combinational from the instruction and the registered flags. A writeback in the same cycle therefore does not affect that cycle's decision.

Computing the branch target, fetching instructions and handling traps belong to neighbouring logic.

Top module: `cc_branch_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, the flags read 3'b010 (zero set). Flag bit order is {neg, zero, pos}, with neg at bit 2.
- R2: A writeback whose value has bit 15 set makes the flags read 3'b100 after the next rising clock edge.
- R3: A writeback of the value 0 makes the flags read 3'b010 after the next rising clock edge.
- R4: A writeback of a nonzero value with bit 15 clear makes the flags read 3'b001 after the next rising clock edge.
- R5: A cycle with the writeback strobe low leaves the flags unchanged, whatever the value input carries.
- R6: Exactly one flag bit is set in every cycle.
- R7: When insn[15:12] is 4'b0000, br_taken is high in the same cycle exactly when (insn[11:9] & flags) is nonzero. insn[11:9] is ordered {neg, zero, pos}, like the flags.
- R8: With the branch opcode, a condition field of 3'b111 is always taken and 3'b000 is never taken.
- R9: br_taken is low whenever insn[15:12] is not 4'b0000.
- R10: When a writeback and a branch occur in the same cycle, the decision uses the flags held before that writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_en | input | 1 | Register writeback strobe |
| wb_value | input | 16 | Value being written to the register file |
| insn | input | 16 | Currently fetched instruction word |
| flags | output | 3 | Stored flags {neg, zero, pos} |
| br_taken | output | 1 | Conditional branch taken |

## Verification
br_taken is combinational, so it is due in the same cycle the instruction is applied. The flags become due one rising edge after a writeback. The bench drives inputs on the falling edge and samples br_taken 1 ns later, before the next rising edge, against flags it models from earlier writebacks. It then samples the flags 1 ns after the rising edge and compares them with the classification of the value just written. Because br_taken is sampled before the edge, a writeback in the same cycle is checked against the older flags, as R10 requires.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
    localparam int DATA_W   = 16;
    localparam int INSN_W   = 16;
    localparam int OPC_W    = 4;
    localparam int OPC_LSB  = INSN_W - OPC_W;
    localparam int CC_W     = 3;
    localparam int MASK_LSB = OPC_LSB - CC_W;
    localparam logic [OPC_W-1:0] OPC_BR = '0;

    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
    } cc_t;

    localparam cc_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/cc_classify.sv
`timescale 1ns/1ps
module cc_classify
    import cc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] value,
    output cc_t          cls
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero  = ~|value;
        is_neg   = value[W-1];
        cls.neg  = is_neg;
        cls.zero = is_zero;
        cls.pos  = ~is_neg & ~is_zero;
    end
endmodule

// File: rtl/cc_resolve.sv
`timescale 1ns/1ps
module cc_resolve
    import cc_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int MW = CC_W
) (
    input  logic [OW-1:0] opcode,
    input  logic [MW-1:0] cond,
    input  logic [MW-1:0] state,
    output logic          taken
);
    logic [MW-1:0] hit;

    for (genvar i = 0; i < MW; i++) begin : g_hit
        assign hit[i] = cond[i] & state[i];
    end

    assign taken = (opcode == OPC_BR) && (|hit);
endmodule

// File: rtl/cc_branch_unit.sv
`timescale 1ns/1ps
module cc_branch_unit
    import cc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = INSN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_en,
    input  logic [DW-1:0] wb_value,
    input  logic [IW-1:0] insn,
    output logic [CC_W-1:0] flags,
    output logic          br_taken
);
    localparam int OP_HI   = IW - 1;
    localparam int OP_LO   = IW - OPC_W;
    localparam int CD_HI   = OP_LO - 1;
    localparam int CD_LO   = OP_LO - CC_W;

    typedef struct packed {
        cc_t cc;
    } state_t;

    state_t st_d, st_q;
    cc_t    wb_cls;
    logic   unused_insn_bits;

    assign unused_insn_bits = ^insn[CD_LO-1:0];

    cc_classify #(.W(DW)) u_cls (
        .value (wb_value),
        .cls   (wb_cls)
    );

    always_comb begin
        st_d = st_q;
        if (wb_en) begin
            st_d.cc = wb_cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cc <= CC_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.cc;

    cc_resolve #(.OW(OPC_W), .MW(CC_W)) u_res (
        .opcode (insn[OP_HI:OP_LO]),
        .cond   (insn[CD_HI:CD_LO]),
        .state  (st_q.cc),
        .taken  (br_taken)
    );
endmodule

// File: rtl/cc_branch_unit_chk.sv
`timescale 1ns/1ps
module cc_branch_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wb_en,
    input logic [15:0] wb_value,
    input logic [15:0] insn,
    input logic [2:0]  flags,
    input logic        br_taken
);
    p_wb_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_value[15]) |=> (flags == 3'b100));

    p_wb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_value == 16'h0000) |=> (flags == 3'b010));

    p_wb_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !wb_value[15] && wb_value != 16'h0000) |=> (flags == 3'b001));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en |=> $stable(flags));

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1);

    p_taken_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> ((insn[11:9] & flags) != 3'b000));

    p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[15:9] == 7'b0000111) |-> br_taken);

    p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[11:9] == 3'b000) |-> !br_taken);

    p_opcode_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn[15:12] != 4'b0000) |-> !br_taken);
endmodule

bind cc_branch_unit cc_branch_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_en    (wb_en),
    .wb_value (wb_value),
    .insn     (insn),
    .flags    (flags),
    .br_taken (br_taken)
);

// File: tb/sim_cc_branch_unit.sv
`timescale 1ns/1ps
module sim_cc_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_en = 1'b0;
    logic [15:0] wb_value = '0;
    logic [15:0] insn = '0;
    logic [2:0]  flags;
    logic        br_taken;

    int checks = 0;
    int fails  = 0;
    logic [2:0] model = 3'b010;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cc_branch_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_en    (wb_en),
        .wb_value (wb_value),
        .insn     (insn),
        .flags    (flags),
        .br_taken (br_taken)
    );

    function automatic logic [2:0] classify(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0000) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic exp_taken(input logic [15:0] i, input logic [2:0] f);
        return (i[15:12] == 4'b0000) && ((i[11:9] & f) != 3'b000);
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic we, input logic [15:0] v, input logic [15:0] i,
                        input string ttag, input string ftag);
        @(negedge clk);
        wb_en = we; wb_value = v; insn = i;
        #1;
        chk(ttag, {3'b000, br_taken}, {3'b000, exp_taken(i, model)});
        @(posedge clk);
        #1;
        if (we) model = classify(v);
        chk(ftag, {1'b0, flags}, {1'b0, model});
        chk("R6", 4'($countones(flags)), 4'd1);
    endtask

    function automatic logic [15:0] br(input logic [2:0] m);
        return {4'b0000, m, 9'h0A5};
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {1'b0, flags}, 4'b0010);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", {1'b0, flags}, 4'b0010);

        step(1'b1, 16'h8000, br(3'b100), "R7", "R2");
        step(1'b1, 16'hFFFF, br(3'b100), "R7", "R2");
        step(1'b1, 16'h0000, br(3'b010), "R7", "R3");
        step(1'b1, 16'h0001, br(3'b001), "R7", "R4");
        step(1'b1, 16'h7FFF, br(3'b011), "R7", "R4");
        step(1'b0, 16'h0000, br(3'b001), "R7", "R5");
        step(1'b0, 16'h8000, br(3'b001), "R7", "R5");

        for (int s = 0; s < 3; s++) begin
            logic [15:0] v;
            v = (s == 0) ? 16'h9000 : (s == 1) ? 16'h0000 : 16'h0042;
            step(1'b1, v, 16'hF000, "R9", "R2");
            for (int m = 0; m < 8; m++) begin
                step(1'b0, 16'h1234, br(3'(m)), "R8", "R5");
                step(1'b0, 16'h1234, {4'(m + 1), 3'b111, 9'h1FF}, "R9", "R5");
            end
        end

        step(1'b1, 16'h0000, 16'h0000, "R7", "R3");
        step(1'b1, 16'h8000, br(3'b010), "R10", "R2");
        step(1'b0, 16'h0000, br(3'b010), "R10", "R5");
        step(1'b1, 16'h0005, br(3'b100), "R10", "R4");

        for (int k = 0; k < 2000; k++) begin
            logic [15:0] v;
            logic [15:0] i;
            logic we;
            we = $urandom_range(0, 2) != 0;
            case ($urandom_range(0, 3))
                0: v = 16'h0000;
                1: v = {1'b1, 15'($urandom)};
                default: v = 16'($urandom);
            endcase
            i = 16'($urandom);
            if ($urandom_range(0, 1) == 1) i[15:12] = 4'b0000;
            step(we, v, i, "R7", we ? "R2" : "R5");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule